// File: doc/BRIEF.md
# Slot-Based 128-bit Working-Key Generator

This block keeps a table of key slots. Each slot can hold two 128-bit half-keys, called X and Y, and one 128-bit working key. A single global 128-bit generator constant is shared by all slots. Software or a loader writes values through one write port. The port carries a kind code, a slot index and 128 bits of data. A cipher engine reads a slot's working key, with a valid flag, through a separate read port.

A write of one half-key can complete a slot, meaning the other half and the constant are already present. In that case a short pipelined datapath derives the working key: rotate X left by 2, XOR with Y, add the constant modulo 2^128, then rotate left by 87. While this runs the block reports busy and holds off further writes. A working key can also be written directly. A clear input wipes every slot and the constant in one cycle.

Top module: `keyslot_scrambler`

## Requirements
- R1: After reset, wr_ready is 1, busy is 0, wr_err is 0, and every slot reads back rd_valid 0 with rd_key all zeros.
- R2: A derived working key equals rotl(((rotl(X,2) XOR Y) + C) mod 2^128, 87). Vectors are big-endian: bit 127 is the most significant bit of byte 0. The carry out of bit 127 is dropped. A rotate by r moves bits toward the MSB by r mod 128 places and wraps.
- R3: Kind code 0 writes X and kind code 1 writes Y. A derivation starts only when the other half of the same slot and the constant are already valid. Otherwise busy stays 0 and the slot's working key is unchanged.
- R4: busy is high for exactly 3 cycles, starting one cycle after the triggering write is accepted. The new key and its valid flag can be read once busy has fallen.
- R5: While busy is high, wr_ready is 0 and an offered write is neither accepted nor applied. It is accepted on the first cycle that wr_ready is 1 again.
- R6: Kind code 2 writes the working key directly. It becomes valid at once, replacing any previous value, without raising busy.
- R7: Kind code 3 loads the generator constant and ignores the index. It never starts a derivation, even for slots that already hold both halves. Later derivations use the new constant.
- R8: clr invalidates every X, Y and working key and the constant. A derivation in progress is abandoned and its result is never stored. A write offered in the same cycle as clr is discarded.
- R9: An X, Y or working-key write with an index of 64 or more changes no state and starts no derivation. It makes wr_err high for the single cycle after acceptance. No other write raises wr_err.
- R10: Reads have one cycle of latency. An index with no valid working key, including any index of 64 or more, returns zeros with rd_valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_kind | input | 2 | 0 = X, 1 = Y, 2 = working key, 3 = generator constant |
| wr_idx | input | 7 | Slot index of the write |
| wr_data | input | 128 | Key value, big-endian |
| wr_err | output | 1 | One-cycle pulse after an accepted out-of-range write |
| clr | input | 1 | Invalidate all keys and the constant |
| rd_idx | input | 7 | Slot index to read |
| rd_key | output | 128 | Working key, zero when not valid |
| rd_valid | output | 1 | Working key of the read slot is valid |
| busy | output | 1 | Derivation in progress |

## Verification
The hardest situations to create from the ports are the ones that overlap a derivation in flight. One is a write held against a low wr_ready, with the old working key still visible on the read port. The other is a clear landing in the middle of the three busy cycles, so that the result must never be stored. The bench starts a derivation, keeps a different write offered at the following falling edges, and counts the stalled cycles before that write lands. In a separate run it raises clr one cycle into a derivation and then shows that the slot and the constant are both gone. The derivation itself is compared against a byte-wise rotate and carry model over every slot. One pattern makes the add carry out of bit 127.

// File: rtl/keyslot_pkg.sv
package keyslot_pkg;
  typedef enum logic [1:0] {
    KIND_X    = 2'd0,
    KIND_Y    = 2'd1,
    KIND_NORM = 2'd2,
    KIND_GEN  = 2'd3
  } key_kind_e;
endpackage

// File: rtl/kss_rotl.sv
// Constant left rotate; a zero amount collapses to a wire.
module kss_rotl #(
  parameter int W   = 128,
  parameter int AMT = 0
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int S = AMT % W;
  generate
    if (S == 0) begin : g_pass
      assign dout = din;
    end else begin : g_rot
      assign dout = (din << S) | (din >> (W - S));
    end
  endgenerate
endmodule

// File: rtl/kss_keymem.sv
// One write port, one registered read port, no reset: maps to block RAM.
module kss_keymem #(
  parameter int DEPTH = 64,
  parameter int W     = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/kss_derive.sv
// Three-stage working-key derivation: mix, add, rotate-out.
module kss_derive #(
  parameter int W     = 128,
  parameter int SW    = 6,
  parameter int ROT_A = 2,
  parameter int ROT_B = 87
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          abort,
  input  logic          start,
  input  logic          start_is_x,
  input  logic [W-1:0]  start_half,
  input  logic [SW-1:0] start_slot,
  input  logic [W-1:0]  x_q,
  input  logic [W-1:0]  y_q,
  input  logic [W-1:0]  gen_key,
  output logic          busy,
  output logic          done,
  output logic [SW-1:0] res_slot,
  output logic [W-1:0]  res_key
);
  typedef enum logic [1:0] {D_IDLE, D_MIX, D_ADD, D_OUT} stage_e;

  stage_e        stage;
  logic [W-1:0]  held;
  logic          held_is_x;
  logic [SW-1:0] slot_q;
  logic [W-1:0]  acc;
  logic [W-1:0]  x_op, y_op, x_rot, mix;

  // The freshly written half is held; the stored half comes from RAM.
  always_comb begin
    x_op = held_is_x ? held : x_q;
    y_op = held_is_x ? y_q  : held;
    mix  = x_rot ^ y_op;
  end

  kss_rotl #(.W(W), .AMT(ROT_A)) u_pre  (.din(x_op), .dout(x_rot));
  kss_rotl #(.W(W), .AMT(ROT_B)) u_post (.din(acc),  .dout(res_key));

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      stage <= D_IDLE;
    end else begin
      case (stage)
        D_IDLE:  if (start) stage <= D_MIX;
        D_MIX:   stage <= D_ADD;
        D_ADD:   stage <= D_OUT;
        default: stage <= D_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (stage == D_IDLE && start) begin
      held      <= start_half;
      held_is_x <= start_is_x;
      slot_q    <= start_slot;
    end
    if (stage == D_MIX) acc <= mix;
    if (stage == D_ADD) acc <= acc + gen_key;
  end

  assign busy     = (stage != D_IDLE);
  assign done     = (stage == D_OUT);
  assign res_slot = slot_q;
endmodule

// File: rtl/keyslot_scrambler.sv
module keyslot_scrambler
  import keyslot_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int KEY_W     = 128,
  parameter int IDX_W     = 7,
  parameter int ROT_PRE   = 2,
  parameter int ROT_POST  = 87
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [1:0]       wr_kind,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_data,
  output logic             wr_err,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [KEY_W-1:0] rd_key,
  output logic             rd_valid,
  output logic             busy
);
  localparam int SW = $clog2(NUM_SLOTS);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_SLOTS);

  key_kind_e      kind;
  logic           accept, in_rng, rd_in_rng;
  logic [SW-1:0]  wslot, rslot;
  logic           wr_x, wr_y, wr_n, wr_c, start;
  logic [NUM_SLOTS-1:0] x_vld, y_vld, n_vld;
  logic           c_vld;
  logic [KEY_W-1:0] c_key;
  logic [KEY_W-1:0] x_q, y_q, n_q;
  logic           d_busy, d_done, commit;
  logic [SW-1:0]  d_slot;
  logic [KEY_W-1:0] d_key;
  logic           n_we;
  logic [SW-1:0]  n_waddr;
  logic [KEY_W-1:0] n_wdata;
  logic           err_q, rdv_q;

  assign kind      = key_kind_e'(wr_kind);
  assign wr_ready  = !d_busy;
  assign accept    = wr_valid && wr_ready && !clr;
  assign in_rng    = (wr_idx < LIMIT);
  assign rd_in_rng = (rd_idx < LIMIT);
  assign wslot     = wr_idx[SW-1:0];
  assign rslot     = rd_idx[SW-1:0];

  assign wr_x  = accept && in_rng && (kind == KIND_X);
  assign wr_y  = accept && in_rng && (kind == KIND_Y);
  assign wr_n  = accept && in_rng && (kind == KIND_NORM);
  assign wr_c  = accept && (kind == KIND_GEN);
  assign start = c_vld && ((wr_x && y_vld[wslot]) || (wr_y && x_vld[wslot]));

  assign commit  = d_done && !clr;
  assign n_we    = wr_n || commit;
  assign n_waddr = commit ? d_slot : wslot;
  assign n_wdata = commit ? d_key : wr_data;

  kss_keymem #(.DEPTH(NUM_SLOTS), .W(KEY_W)) u_xmem (
    .clk(clk), .we(wr_x), .waddr(wslot), .wdata(wr_data), .raddr(wslot), .rdata(x_q));
  kss_keymem #(.DEPTH(NUM_SLOTS), .W(KEY_W)) u_ymem (
    .clk(clk), .we(wr_y), .waddr(wslot), .wdata(wr_data), .raddr(wslot), .rdata(y_q));
  kss_keymem #(.DEPTH(NUM_SLOTS), .W(KEY_W)) u_nmem (
    .clk(clk), .we(n_we), .waddr(n_waddr), .wdata(n_wdata), .raddr(rslot), .rdata(n_q));

  kss_derive #(.W(KEY_W), .SW(SW), .ROT_A(ROT_PRE), .ROT_B(ROT_POST)) u_derive (
    .clk(clk), .rst(rst), .abort(clr), .start(start), .start_is_x(wr_x),
    .start_half(wr_data), .start_slot(wslot), .x_q(x_q), .y_q(y_q),
    .gen_key(c_key), .busy(d_busy), .done(d_done), .res_slot(d_slot), .res_key(d_key));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      x_vld <= '0;
      y_vld <= '0;
      n_vld <= '0;
      c_vld <= 1'b0;
    end else begin
      if (wr_x) x_vld[wslot]  <= 1'b1;
      if (wr_y) y_vld[wslot]  <= 1'b1;
      if (n_we) n_vld[n_waddr] <= 1'b1;
      if (wr_c) c_vld <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) c_key <= '0;
    else if (wr_c) c_key <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= 1'b0;
      rdv_q <= 1'b0;
    end else begin
      err_q <= accept && (kind != KIND_GEN) && !in_rng;
      rdv_q <= rd_in_rng && n_vld[rslot];
    end
  end

  assign wr_err   = err_q;
  assign rd_valid = rdv_q;
  assign rd_key   = rdv_q ? n_q : '0;
  assign busy     = d_busy;
endmodule

// File: rtl/keyslot_scrambler_chk.sv
module keyslot_scrambler_chk #(
  parameter int NUM_SLOTS = 64,
  parameter int IDX_W     = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [1:0]       wr_kind,
  input logic [IDX_W-1:0] wr_idx,
  input logic             clr,
  input logic             busy,
  input logic             wr_err,
  input logic             rd_valid,
  input logic             c_vld
);
  logic acc;
  logic bad_idx;
  assign acc     = wr_valid && wr_ready && !clr;
  assign bad_idx = (int'(wr_idx) >= NUM_SLOTS);

  AST_BUSY_THREE: assert property (@(posedge clk) disable iff (rst || clr)
    $rose(busy) |=> busy ##1 busy ##1 !busy); // R4

  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> $past(acc && bad_idx && wr_kind != 2'd3)); // R9

  AST_BAD_IDX_IDLE: assert property (@(posedge clk) disable iff (rst)
    (acc && bad_idx) |=> !busy); // R9

  AST_NO_GEN_NO_DERIVE: assert property (@(posedge clk) disable iff (rst)
    (acc && !c_vld && wr_kind[1] == 1'b0) |=> !busy); // R3

  AST_GEN_NO_REDERIVE: assert property (@(posedge clk) disable iff (rst)
    (acc && wr_kind == 2'd3) |=> !busy); // R7

  AST_NORM_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (acc && wr_kind == 2'd2) |=> !busy); // R6

  AST_CLR_WIPES: assert property (@(posedge clk) disable iff (rst)
    clr |=> ##1 !rd_valid); // R8
endmodule

bind keyslot_scrambler keyslot_scrambler_chk #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_kind(wr_kind),
  .wr_idx(wr_idx), .clr(clr), .busy(busy), .wr_err(wr_err), .rd_valid(rd_valid),
  .c_vld(c_vld));

// File: tb/keyslot_scrambler_tb.sv
`timescale 1ns/1ps
module keyslot_scrambler_tb;
  localparam int NS = 64;
  localparam int KW = 128;
  localparam int IW = 7;
  localparam logic [1:0] KX = 2'd0, KY = 2'd1, KN = 2'd2, KC = 2'd3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [1:0]    wr_kind = '0;
  logic [IW-1:0] wr_idx = '0;
  logic [KW-1:0] wr_data = '0;
  logic          wr_err;
  logic          clr = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [KW-1:0] rd_key;
  logic          rd_valid;
  logic          busy;

  always #5 clk = ~clk;

  keyslot_scrambler u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_kind(wr_kind),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err), .clr(clr), .rd_idx(rd_idx),
    .rd_key(rd_key), .rd_valid(rd_valid), .busy(busy));

  int n_chk = 0;
  int n_err = 0;

  logic [KW-1:0] m_x [NS];
  logic [KW-1:0] m_y [NS];
  logic [KW-1:0] m_n [NS];
  bit            m_xv [NS];
  bit            m_yv [NS];
  bit            m_nv [NS];
  bit            m_cv;
  logic [KW-1:0] m_c;

  task automatic chk(input bit ok, input string req, input logic [KW-1:0] act,
                     input logic [KW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Byte-wise model of the rotate: byte 0 is the most significant byte.
  function automatic logic [KW-1:0] m_rot(input logic [KW-1:0] v, input int r);
    int b [16];
    int o;
    int bs, bt;
    logic [KW-1:0] res;
    for (int i = 0; i < 16; i++) b[i] = int'(v[127-8*i -: 8]);
    r  = r % 128;
    bs = r / 8;
    bt = r % 8;
    for (int i = 0; i < 16; i++) begin
      o = ((b[(i + bs) % 16] << bt) | (b[(i + bs + 1) % 16] >> (8 - bt))) & 255;
      res[127-8*i -: 8] = 8'(o);
    end
    return res;
  endfunction

  function automatic logic [KW-1:0] m_add(input logic [KW-1:0] a, input logic [KW-1:0] b);
    int carry = 0;
    int s;
    logic [KW-1:0] res;
    for (int i = 15; i >= 0; i--) begin
      s = int'(a[127-8*i -: 8]) + int'(b[127-8*i -: 8]) + carry;
      carry = s >> 8;
      res[127-8*i -: 8] = 8'(s & 255);
    end
    return res;
  endfunction

  function automatic logic [KW-1:0] m_derive(input logic [KW-1:0] x, input logic [KW-1:0] y,
                                             input logic [KW-1:0] c);
    return m_rot(m_add(m_rot(x, 2) ^ y, c), 87);
  endfunction

  function automatic logic [KW-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NS; i++) begin
      m_xv[i] = 0; m_yv[i] = 0; m_nv[i] = 0;
    end
    m_cv = 0;
  endtask

  // Model update for an accepted write; returns whether a derivation starts.
  function automatic bit model_apply(input logic [1:0] k, input int idx, input logic [KW-1:0] d);
    bit der = 0;
    if (k == KC) begin
      m_c = d; m_cv = 1;
    end else if (idx < NS) begin
      if (k == KX) begin
        der = m_yv[idx] && m_cv;
        m_x[idx] = d; m_xv[idx] = 1;
      end else if (k == KY) begin
        der = m_xv[idx] && m_cv;
        m_y[idx] = d; m_yv[idx] = 1;
      end else begin
        m_n[idx] = d; m_nv[idx] = 1;
      end
      if (der) begin
        m_n[idx] = m_derive(m_x[idx], m_y[idx], m_c);
        m_nv[idx] = 1;
      end
    end
    return der;
  endfunction

  task automatic do_write(input logic [1:0] k, input int idx, input logic [KW-1:0] d);
    bit der;
    int cyc;
    @(negedge clk);
    wr_valid = 1'b1; wr_kind = k; wr_idx = IW'(idx); wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    der = model_apply(k, idx, d);
    chk(wr_err == (k != KC && idx >= NS), "R9 wr_err", KW'(wr_err), KW'(k != KC && idx >= NS));
    chk(busy == der, "R3 busy after write", KW'(busy), KW'(der));
    if (der) begin
      cyc = 0;
      while (busy && cyc < 10) begin
        cyc++;
        @(negedge clk);
      end
      chk(cyc == 3, "R4 busy length", KW'(cyc), KW'(3));
      chk(wr_err == 1'b0, "R9 no repeat pulse", KW'(wr_err), KW'(0));
    end
  endtask

  task automatic rd_chk(input int idx, input string req);
    logic [KW-1:0] ek;
    bit ev;
    @(negedge clk);
    rd_idx = IW'(idx);
    @(negedge clk);
    ev = (idx < NS) ? m_nv[idx] : 1'b0;
    ek = ev ? m_n[idx] : '0;
    chk(rd_valid == ev, {req, " rd_valid"}, KW'(rd_valid), KW'(ev));
    chk(rd_key == ek, {req, " rd_key"}, rd_key, ek);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R4 watchdog act=timeout exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [KW-1:0] v21, vx;
    model_clear();
    m_c = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(wr_ready == 1'b1, "R1 wr_ready", KW'(wr_ready), KW'(1));
    chk(busy == 1'b0, "R1 busy", KW'(busy), KW'(0));
    chk(wr_err == 1'b0, "R1 wr_err", KW'(wr_err), KW'(0));
    for (int i = 0; i < NS; i++) rd_chk(i, "R1");

    // R3: halves without constant never derive
    do_write(KX, 5, rnd128());
    rd_chk(5, "R3 no derive");
    do_write(KY, 5, rnd128());
    rd_chk(5, "R3 no constant");
    // R7: constant load does not re-derive a complete slot
    do_write(KC, 99, KW'(1));
    rd_chk(5, "R7 no rederive");
    // R2/R4: rewrite X with Y and C present
    do_write(KX, 5, rnd128());
    rd_chk(5, "R2 derive slot5");

    // R2 carry wrap: (0 ^ ones) + 1 wraps to zero
    do_write(KX, 0, '0);
    do_write(KY, 0, '1);
    rd_chk(0, "R2 carry discard");

    // Sweep every slot, X then Y (Y write triggers); constant changes halfway
    for (int i = 1; i < NS; i++) begin
      if (i == 32) do_write(KC, 0, rnd128());
      if (i != 5) begin
        do_write(KX, i, rnd128());
        do_write(KY, i, rnd128());
      end
      rd_chk(i, "R2 sweep");
    end
    rd_chk(0, "R7 old result kept");

    // R6: direct working-key write
    do_write(KN, 10, 128'h0123456789abcdeffedcba9876543210);
    rd_chk(10, "R6 direct");

    // R9: out-of-range writes
    do_write(KX, 64, rnd128());
    do_write(KN, 127, rnd128());
    rd_chk(0, "R9 slot0 intact");
    // R10: out-of-range read
    rd_chk(100, "R10 oob read");

    // R5: write held while busy
    v21 = 128'hdeadbeef_00000000_cafef00d_12345678;
    vx = rnd128();
    @(negedge clk);
    rd_idx = IW'(21);
    wr_valid = 1'b1; wr_kind = KX; wr_idx = IW'(3); wr_data = vx;
    @(negedge clk);
    void'(model_apply(KX, 3, vx));
    wr_kind = KN; wr_idx = IW'(21); wr_data = v21;
    for (int c = 0; c < 3; c++) begin
      chk(wr_ready == 1'b0, "R5 ready low", KW'(wr_ready), KW'(0));
      chk(rd_key == m_n[21], "R5 held write not applied", rd_key, m_n[21]);
      @(negedge clk);
    end
    chk(wr_ready == 1'b1, "R5 ready back", KW'(wr_ready), KW'(1));
    @(negedge clk);
    wr_valid = 1'b0;
    void'(model_apply(KN, 21, v21));
    rd_chk(21, "R5 held write lands");
    rd_chk(3, "R4 derived after stall");

    // R8: clear during a derivation
    vx = rnd128();
    @(negedge clk);
    wr_valid = 1'b1; wr_kind = KX; wr_idx = IW'(9); wr_data = vx;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(busy == 1'b1, "R8 derivation running", KW'(busy), KW'(1));
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    model_clear();
    chk(busy == 1'b0, "R8 abort", KW'(busy), KW'(0));
    repeat (4) @(negedge clk);
    for (int i = 0; i < NS; i++) rd_chk(i, "R8 wiped");
    do_write(KX, 9, rnd128());
    do_write(KY, 9, rnd128());
    rd_chk(9, "R8 constant wiped");
    do_write(KC, 0, rnd128());
    do_write(KX, 9, rnd128());
    rd_chk(9, "R8 derive after reload");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule